// File: doc/BRIEF.md
# Fast-Settling Sinc4 Decimator with Averaging Postfilter

This block turns the 1-bit output stream of a sigma-delta modulator into signed conversion results. A fourth-order sinc (cascaded integrator-comb) stage decimates by `DEC_BASE` times a rate word. Each modulator bit counts as +1 when it is 1 and -1 when it is 0. An averaging postfilter then takes the mean of a selectable number of consecutive sinc outputs. Every conversion starts from cleared filter state. The first three sinc outputs of a conversion are dropped because they are not fully settled, and the next Avg outputs are summed and divided by Avg. Each result therefore depends only on the samples of its own conversion. The conversion time stays the same whether one input or several multiplexed inputs are being measured, and a channel change costs no extra time.

A pulse on `conv_start` marks a channel change. It abandons any conversion in progress, latches the rate word, the averaging select and the chop flag, and begins a fresh conversion. After each result the block starts the next conversion on its own and latches the configuration inputs again at that point. When the chop flag is latched, the first result after a start is marked as not settled, because a chopped front end needs two output periods to settle after a step.

Control is a four-state machine:
- `ST_IDLE`: no conversion runs. A start with a non-zero select moves to `ST_FLUSH`.
- `ST_FLUSH`: counts the three discarded sinc outputs. The third moves to `ST_ACCUM`.
- `ST_ACCUM`: sums Avg sinc outputs. The last one moves to `ST_EMIT`.
- `ST_EMIT`: delivers the result and clears the filter. It then moves to `ST_FLUSH`, or to `ST_IDLE` if the select is now 00.

In any state, a start moves to `ST_FLUSH`, or to `ST_IDLE` when the select is 00.

Top module: `sfs_fast_settle_top`

## Requirements
- R1: The decimation ratio is R = `DEC_BASE` × `rate_word`, and a rate word of 0 acts as 1. One conversion consumes exactly (3 + Avg) × R accepted modulator samples, and each conversion yields exactly one result.
- R2: With bit 1 weighted +1 and bit 0 weighted -1, the result equals the sum of sinc4 outputs 4 through 3+Avg of the conversion (each taken from zero filter state), arithmetically shifted right by log2(Avg). When the sinc width exceeds `OUT_W`, the result is the top `OUT_W` bits; otherwise it is sign-extended.
- R3: The averaging select codes 01, 10 and 11 choose Avg = 2, 8 and 16. Code 00 leaves the block idle, and no result appears however many samples arrive.
- R4: Filter and averager state is cleared at the start of every conversion, so each result is unaffected by samples of earlier conversions.
- R5: With a steady sample stream, consecutive results are spaced by exactly (3 + Avg) × R sample periods.
- R6: A `conv_start` pulse abandons the running conversion without producing a result from it. The next conversion uses only samples accepted after the pulse, and `result_valid` is low in the cycle after the pulse.
- R7: `result_valid` is high for exactly one clock per result, and `result` holds its value between results.
- R8: When chop was latched at the start, the first result after that start has `result_settled` = 0 and later results have 1. With chop off, every result has `result_settled` = 1.
- R9: After reset, `result`, `result_valid` and `result_settled` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_en | input | 1 | Modulator sample strobe, one clock per bit |
| mod_bit | input | 1 | Modulator output bit |
| rate_word | input | RATE_W | Decimation rate multiplier, 0 treated as 1 |
| avg_sel | input | 2 | Averaging select: 00 off, 01 by 2, 10 by 8, 11 by 16 |
| conv_start | input | 1 | Start or channel-change pulse |
| chop_en | input | 1 | Chopped front end; marks the first result as unsettled |
| result | output | OUT_W | Signed conversion result |
| result_valid | output | 1 | One-clock pulse when `result` is new |
| result_settled | output | 1 | The current result is fully settled |

## Verification
The bench builds the block with `DEC_BASE` = 4 and `RATE_W` = 2, so R is at most 12 and a conversion is at most 228 samples long. This makes a full sweep practical: every rate word including 0, every averaging code, and four bit patterns (all ones, all zeros, alternating, and a scrambled sequence), with two back-to-back conversions each. The expected values come from a sinc4 impulse response that the bench builds by convolving boxes, so results, spacing, the chop settle flag, abort on start and the idle select can all be compared arithmetically. With these parameters the 17-bit sinc width fits inside the 24-bit output, so results are compared without truncation.

// File: rtl/sfs_pkg.sv
package sfs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FLUSH = 2'd1,
        ST_ACCUM = 2'd2,
        ST_EMIT  = 2'd3
    } sfs_state_e;

    localparam int SINC_ORDER   = 4;
    localparam int DISCARD_OUTS = SINC_ORDER - 1;

    // log2 of the averaging count for a select code
    function automatic logic [2:0] avg_shift(input logic [1:0] sel);
        unique case (sel)
            2'b01:   return 3'd1;
            2'b10:   return 3'd3;
            2'b11:   return 3'd4;
            default: return 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/sfs_sinc4.sv
module sfs_sinc4
    import sfs_pkg::*;
#(
    parameter int RATE_W   = 10,
    parameter int DEC_BASE = 1024,
    parameter int SINC_W   = 81
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear,
    input  logic                     sample_en,
    input  logic                     sample_bit,
    input  logic [RATE_W-1:0]        rate,
    output logic                     dec_valid,
    output logic signed [SINC_W-1:0] dec_data
);

    localparam int RMAX  = DEC_BASE * ((1 << RATE_W) - 1);
    localparam int CNT_W = $clog2(RMAX + 1);

    logic [CNT_W-1:0]         fs_eff;
    logic [CNT_W-1:0]         period;
    logic [CNT_W-1:0]         phase_q;
    logic signed [SINC_W-1:0] x_s;
    logic signed [SINC_W-1:0] integ_q [SINC_ORDER];
    logic signed [SINC_W-1:0] integ_d [SINC_ORDER];
    logic signed [SINC_W-1:0] dly_q   [SINC_ORDER];
    logic signed [SINC_W-1:0] diff    [SINC_ORDER];

    always_comb begin
        fs_eff = (rate == '0) ? CNT_W'(1) : CNT_W'(rate);
        period = fs_eff * CNT_W'(DEC_BASE);
        x_s    = sample_bit ? SINC_W'(1) : '1;
    end

    // integrator cascade then comb cascade, full rate into decimated rate
    always_comb begin
        integ_d[0] = integ_q[0] + x_s;
        for (int k = 1; k < SINC_ORDER; k++)
            integ_d[k] = integ_q[k] + integ_d[k-1];
        diff[0] = integ_d[SINC_ORDER-1] - dly_q[0];
        for (int k = 1; k < SINC_ORDER; k++)
            diff[k] = diff[k-1] - dly_q[k];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < SINC_ORDER; k++) begin
                integ_q[k] <= '0;
                dly_q[k]   <= '0;
            end
            phase_q   <= '0;
            dec_valid <= 1'b0;
            dec_data  <= '0;
        end else if (clear) begin
            for (int k = 0; k < SINC_ORDER; k++) begin
                integ_q[k] <= '0;
                dly_q[k]   <= '0;
            end
            phase_q   <= '0;
            dec_valid <= 1'b0;
            dec_data  <= '0;
        end else begin
            dec_valid <= 1'b0;
            if (sample_en) begin
                for (int k = 0; k < SINC_ORDER; k++)
                    integ_q[k] <= integ_d[k];
                if (phase_q == period - CNT_W'(1)) begin
                    phase_q   <= '0;
                    dec_valid <= 1'b1;
                    dec_data  <= diff[SINC_ORDER-1];
                    dly_q[0]  <= integ_d[SINC_ORDER-1];
                    for (int k = 1; k < SINC_ORDER; k++)
                        dly_q[k] <= diff[k-1];
                end else begin
                    phase_q <= phase_q + CNT_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/sfs_avg.sv
module sfs_avg #(
    parameter int SINC_W = 81,
    parameter int ACC_W  = 85,
    parameter int OUT_W  = 24
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear,
    input  logic                     add_en,
    input  logic signed [SINC_W-1:0] dec_data,
    input  logic [2:0]               shift_amt,
    input  logic                     emit,
    input  logic                     flag_in,
    output logic signed [OUT_W-1:0]  result,
    output logic                     result_valid,
    output logic                     result_settled
);

    logic signed [ACC_W-1:0]  acc_q;
    logic signed [ACC_W-1:0]  acc_ext;
    logic signed [SINC_W-1:0] mean;
    logic signed [OUT_W-1:0]  scaled;

    assign acc_ext = {{(ACC_W-SINC_W){dec_data[SINC_W-1]}}, dec_data};
    assign mean    = SINC_W'(acc_q >>> shift_amt);

    generate
        if (SINC_W >= OUT_W) begin : g_top_bits
            assign scaled = OUT_W'(mean >>> (SINC_W - OUT_W));
        end else begin : g_sign_ext
            assign scaled = {{(OUT_W-SINC_W){mean[SINC_W-1]}}, mean};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q          <= '0;
            result         <= '0;
            result_valid   <= 1'b0;
            result_settled <= 1'b0;
        end else begin
            if (clear)
                acc_q <= '0;
            else if (add_en)
                acc_q <= acc_q + acc_ext;
            result_valid <= emit;
            if (emit) begin
                result         <= scaled;
                result_settled <= flag_in;
            end
        end
    end

endmodule

// File: rtl/sfs_ctrl.sv
module sfs_ctrl
    import sfs_pkg::*;
#(
    parameter int RATE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        avg_sel,
    input  logic [RATE_W-1:0] rate_in,
    input  logic              chop_in,
    input  logic              dec_valid,
    output logic              clear,
    output logic              add_en,
    output logic              emit,
    output logic [RATE_W-1:0] rate_q,
    output logic [2:0]        shift_q,
    output logic              settled_flag
);

    sfs_state_e  state_q, state_d;
    logic [4:0]  cnt_q;
    logic [4:0]  avg_last;
    logic [1:0]  avgsel_q;
    logic        chop_q;
    logic        first_q;
    logic        restart;

    always_comb begin
        unique case (avgsel_q)
            2'b01:   avg_last = 5'd1;
            2'b10:   avg_last = 5'd7;
            2'b11:   avg_last = 5'd15;
            default: avg_last = 5'd0;
        endcase
    end

    assign restart = start || (state_q == ST_EMIT);

    // next state
    always_comb begin
        state_d = state_q;
        if (start) begin
            state_d = (avg_sel != 2'b00) ? ST_FLUSH : ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_FLUSH: if (dec_valid && cnt_q == 5'(DISCARD_OUTS - 1)) state_d = ST_ACCUM;
                ST_ACCUM: if (dec_valid && cnt_q == avg_last) state_d = ST_EMIT;
                ST_EMIT:  state_d = (avg_sel != 2'b00) ? ST_FLUSH : ST_IDLE;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // phase counter and latched configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            rate_q   <= '0;
            avgsel_q <= 2'b00;
            chop_q   <= 1'b0;
            first_q  <= 1'b0;
        end else if (restart) begin
            cnt_q    <= '0;
            rate_q   <= rate_in;
            avgsel_q <= avg_sel;
            chop_q   <= chop_in;
            first_q  <= start;
        end else if (state_q != state_d) begin
            cnt_q <= '0;
        end else if (dec_valid && (state_q == ST_FLUSH || state_q == ST_ACCUM)) begin
            cnt_q <= cnt_q + 5'd1;
        end
    end

    // outputs
    always_comb begin
        clear        = restart;
        add_en       = (state_q == ST_ACCUM) && dec_valid;
        emit         = (state_q == ST_EMIT) && !start;
        shift_q      = avg_shift(avgsel_q);
        settled_flag = !(chop_q && first_q);
    end

endmodule

// File: rtl/sfs_fast_settle_top.sv
module sfs_fast_settle_top
    import sfs_pkg::*;
#(
    parameter int RATE_W   = 10,
    parameter int DEC_BASE = 1024,
    parameter int OUT_W    = 24
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    mod_en,
    input  logic                    mod_bit,
    input  logic [RATE_W-1:0]       rate_word,
    input  logic [1:0]              avg_sel,
    input  logic                    conv_start,
    input  logic                    chop_en,
    output logic signed [OUT_W-1:0] result,
    output logic                    result_valid,
    output logic                    result_settled
);

    localparam int RMAX   = DEC_BASE * ((1 << RATE_W) - 1);
    localparam int LOG_R  = $clog2(RMAX);
    localparam int SINC_W = SINC_ORDER * LOG_R + 1;
    localparam int ACC_W  = SINC_W + 4;

    logic                     clear;
    logic                     add_en;
    logic                     emit;
    logic [RATE_W-1:0]        rate_q;
    logic [2:0]               shift_q;
    logic                     settled_flag;
    logic                     dec_valid;
    logic signed [SINC_W-1:0] dec_data;

    sfs_ctrl #(.RATE_W(RATE_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (conv_start),
        .avg_sel      (avg_sel),
        .rate_in      (rate_word),
        .chop_in      (chop_en),
        .dec_valid    (dec_valid),
        .clear        (clear),
        .add_en       (add_en),
        .emit         (emit),
        .rate_q       (rate_q),
        .shift_q      (shift_q),
        .settled_flag (settled_flag)
    );

    sfs_sinc4 #(.RATE_W(RATE_W), .DEC_BASE(DEC_BASE), .SINC_W(SINC_W)) u_sinc (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (clear),
        .sample_en  (mod_en),
        .sample_bit (mod_bit),
        .rate       (rate_q),
        .dec_valid  (dec_valid),
        .dec_data   (dec_data)
    );

    sfs_avg #(.SINC_W(SINC_W), .ACC_W(ACC_W), .OUT_W(OUT_W)) u_avg (
        .clk            (clk),
        .rst_n          (rst_n),
        .clear          (clear),
        .add_en         (add_en),
        .dec_data       (dec_data),
        .shift_amt      (shift_q),
        .emit           (emit),
        .flag_in        (settled_flag),
        .result         (result),
        .result_valid   (result_valid),
        .result_settled (result_settled)
    );

endmodule

// File: rtl/sfs_fast_settle_chk.sv
module sfs_fast_settle_chk #(
    parameter int DEC_BASE = 1024,
    parameter int OUT_W    = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             conv_start,
    input logic             result_valid,
    input logic             result_settled,
    input logic [OUT_W-1:0] result
);

    localparam int MIN_GAP = 5 * DEC_BASE;

    logic [31:0] gap_q;
    logic        prev_unset_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q        <= '0;
            prev_unset_q <= 1'b0;
        end else begin
            if (conv_start || result_valid)
                gap_q <= '0;
            else if (gap_q != 32'hFFFF_FFFF)
                gap_q <= gap_q + 32'd1;
            if (conv_start)
                prev_unset_q <= 1'b0;
            else if (result_valid)
                prev_unset_q <= !result_settled;
        end
    end

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid); // R7

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !result_valid |-> $stable(result)); // R7

    AST_START_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !result_valid); // R6

    AST_MIN_CONV_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> (gap_q >= 32'(MIN_GAP))); // R1

    AST_ONE_UNSETTLED: assert property (@(posedge clk) disable iff (!rst_n)
        (result_valid && prev_unset_q) |-> result_settled); // R8

endmodule

bind sfs_fast_settle_top sfs_fast_settle_chk #(.DEC_BASE(DEC_BASE), .OUT_W(OUT_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .conv_start     (conv_start),
    .result_valid   (result_valid),
    .result_settled (result_settled),
    .result         (result)
);

// File: tb/sfs_fast_settle_top_tb_top.sv
`timescale 1ns/1ps
module sfs_fast_settle_top_tb_top;

    localparam int RATE_W   = 2;
    localparam int DEC_BASE = 4;
    localparam int OUT_W    = 24;
    localparam int SPACING  = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              mod_en = 1'b0;
    logic              mod_bit = 1'b0;
    logic [RATE_W-1:0] rate_word = '0;
    logic [1:0]        avg_sel = 2'b00;
    logic              conv_start = 1'b0;
    logic              chop_en = 1'b0;
    logic [OUT_W-1:0]  result;
    logic              result_valid;
    logic              result_settled;

    sfs_fast_settle_top #(.RATE_W(RATE_W), .DEC_BASE(DEC_BASE), .OUT_W(OUT_W)) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .mod_en         (mod_en),
        .mod_bit        (mod_bit),
        .rate_word      (rate_word),
        .avg_sel        (avg_sel),
        .conv_start     (conv_start),
        .chop_en        (chop_en),
        .result         (result),
        .result_valid   (result_valid),
        .result_settled (result_settled)
    );

    always #2 clk = ~clk;

    int     cyc = 0;
    int     tests = 0;
    int     fails = 0;
    int     nres = 0;
    longint got_val [0:255];
    bit     got_set [0:255];
    int     got_t   [0:255];
    bit     prev_v = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // result monitor, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (result_valid) begin
                if (nres < 256) begin
                    got_val[nres] = longint'($signed(result));
                    got_set[nres] = result_settled;
                    got_t[nres]   = cyc;
                end
                nres++;
            end
            if (result_valid && prev_v) begin
                tests++;
                fails++;
                $display("FAIL R7 valid wider than one clock actual=2 expected=1");
            end
            prev_v = result_valid;
        end
    end

    function automatic int xval(input int pat, input int idx);
        case (pat)
            0:       return 1;
            1:       return -1;
            2:       return (idx % 2 == 1) ? 1 : -1;
            default: return (((idx * 37 + 11) % 13) > 5) ? 1 : -1;
        endcase
    endfunction

    function automatic int avg_of(input int asel);
        return (asel == 1) ? 2 : (asel == 2) ? 8 : 16;
    endfunction

    function automatic int ratio_of(input int fs);
        return DEC_BASE * ((fs == 0) ? 1 : fs);
    endfunction

    // expected result of conversion c of a stream, from the sinc4 impulse response
    function automatic longint expect_res(input int fs, input int asel, input int pat, input int c);
        longint h [0:63];
        longint t [0:63];
        int r, avg, sh, n, len;
        longint sum;
        r   = ratio_of(fs);
        avg = avg_of(asel);
        sh  = (asel == 1) ? 1 : (asel == 2) ? 3 : 4;
        n   = (3 + avg) * r;
        for (int j = 0; j < 64; j++) h[j] = (j < r) ? 1 : 0;
        len = r;
        for (int st = 0; st < 3; st++) begin
            for (int j = 0; j < 64; j++) t[j] = 0;
            for (int j = 0; j < len; j++)
                for (int m = 0; m < r; m++) t[j+m] += h[j];
            len = len + r - 1;
            for (int j = 0; j < 64; j++) h[j] = t[j];
        end
        sum = 0;
        for (int k = 4; k <= 3 + avg; k++) begin
            int nloc;
            nloc = k * r - 1;
            for (int j = 0; j < len; j++)
                if (nloc - j >= 0) sum += h[j] * xval(pat, c * n + nloc - j);
        end
        return sum >>> sh;
    endfunction

    task automatic send(input int v);
        @(negedge clk);
        mod_en  = 1'b1;
        mod_bit = (v > 0);
        @(negedge clk);
        mod_en  = 1'b0;
        repeat (SPACING - 2) @(negedge clk);
    endtask

    task automatic pulse_start(input int fs, input int asel, input bit chop);
        @(negedge clk);
        rate_word  = RATE_W'(fs);
        avg_sel    = 2'(asel);
        chop_en    = chop;
        conv_start = 1'b1;
        @(negedge clk);
        conv_start = 1'b0;
    endtask

    task automatic run_cfg(input int fs, input int asel, input int pat, input bit chop, input int nconv);
        int base, n;
        base = nres;
        n    = (3 + avg_of(asel)) * ratio_of(fs);
        pulse_start(fs, asel, chop);
        for (int s = 0; s < nconv * n; s++) send(xval(pat, s));
        repeat (8) @(negedge clk);
        chk(nres - base == nconv, "R1 R6 result count", nres - base, nconv);
        for (int c = 0; c < nconv; c++) begin
            longint e;
            e = expect_res(fs, asel, pat, c);
            if (c == 0) chk(got_val[base+c] == e, "R2 R3 value", got_val[base+c], e);
            else        chk(got_val[base+c] == e, "R4 value after restart", got_val[base+c], e);
            chk(got_set[base+c] == !(chop && c == 0), "R8 settled flag",
                got_set[base+c], !(chop && c == 0));
        end
        if (nconv >= 2)
            chk(got_t[base+1] - got_t[base] == n * SPACING, "R5 conversion spacing",
                got_t[base+1] - got_t[base], n * SPACING);
        chk(longint'($signed(result)) == got_val[base+nconv-1], "R7 result hold",
            longint'($signed(result)), got_val[base+nconv-1]);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(result == '0, "R9 reset result", longint'(result), 0);
        chk(result_valid == 1'b0, "R9 reset valid", result_valid, 0);
        chk(result_settled == 1'b0, "R9 reset settled", result_settled, 0);

        // sweep of rate words, averaging codes and bit patterns
        for (int fs = 0; fs < 4; fs++)
            for (int asel = 1; asel < 4; asel++)
                for (int pat = 0; pat < 4; pat++)
                    run_cfg(fs, asel, pat, 1'b0, 2);

        // chopped: first result unsettled, later ones settled (R8)
        run_cfg(2, 2, 3, 1'b1, 3);

        // abort a long conversion part way, then a fresh one (R6)
        begin
            int base;
            base = nres;
            pulse_start(3, 3, 1'b0);
            for (int s = 0; s < 30; s++) send(xval(3, s));
            repeat (4) @(negedge clk);
            chk(nres == base, "R6 no result before abort", nres - base, 0);
        end
        run_cfg(1, 1, 2, 1'b0, 2);

        // select 00: block stays idle (R3)
        begin
            int base;
            base = nres;
            pulse_start(1, 0, 1'b0);
            for (int s = 0; s < 120; s++) send(xval(0, s));
            repeat (8) @(negedge clk);
            chk(nres == base, "R3 idle with select 00", nres - base, 0);
        end
        run_cfg(1, 3, 0, 1'b0, 1);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected<200000", cyc);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule